// File: doc/BRIEF.md
# SD card SPI-mode byte responder

This block behaves like the card side of an SD card link in SPI mode, seen one byte at a time. A host raises a select or deselect strobe and presents whole bytes. Each byte exchanged while the card is selected decides the byte the host reads back afterwards, so a response always trails the byte that caused it by one exchange. The block counts the wake-up clocks and then walks the host through the fixed reset-and-identify handshake. After that it accepts 6-byte command frames and serves single 512-byte sector reads and writes.

Sector bytes come from and go to a byte-addressed synchronous memory with one cycle of read latency. During a read the next address is presented early, so host bytes may arrive on every clock cycle. A CRC16 is accumulated over the payload of each read and write. For reads it is appended to the data. For writes it is compared against the two check bytes the host sends, and any mismatch sets a sticky error flag.

Top module: `sd_spi_responder`

## Requirements
- R1: While the card is deselected (after a `cs_high_i` strobe, and from reset), byte writes change no state and `rd_data_o` reads 0xFF. A `cs_low_i` strobe selects the card, and `cs_high_i` wins if both strobes are high together.
- R2: Every byte accepted while selected first sets the pending response to 0xFF, and `rd_data_o` holds the response of the most recent accepted byte until the next one. A command's reply therefore appears on the byte after the frame's sixth byte.
- R3: The first 8 bytes accepted after reset are wake-up clocks. They are ignored even when they form a valid command frame.
- R4: With no frame in progress, a byte outside 0x40..0x7F is dropped. A byte inside that range opens a 6-byte frame whose command number is the byte's low 6 bits. The 32-bit argument is frame bytes 1..4, most significant first, and byte 5 is ignored.
- R5: The handshake accepts commands in a fixed order, with each reply starting on the byte after the frame: command 0 gets 0x01; then command 8 with argument[15:0]=0x01AA gets the five bytes 01 00 00 01 AA; then command 55 gets 0x01; then command 41 with argument[31:16]=0x4000 gets 0x00.
- R6: Before command 0 is accepted, other frames get no reply. Any other frame at the command-8, command-55 or command-41 stage gets no reply and returns the handshake to waiting for command 0.
- R7: Once initialized, command 17 replies 0x00, then 0xFE, then the 512 bytes at memory address argument[15:0]*512 + i in ascending order, then the CRC16 high byte and then its low byte.
- R8: Command 24 replies 0x00 on the next byte. After that, 0xFF bytes are skipped until a 0xFE token arrives. The following 512 bytes are written to argument[15:0]*512 + i. After two more check bytes, the next exchange returns 0x05.
- R9: While command 24 waits for its token, a byte other than 0xFF and 0xFE cancels the write. No memory is written, and later bytes are parsed as commands again.
- R10: The data CRC is CRC16 with polynomial 0x1021, initial value 0, processed most significant bit first, once per payload byte (tokens excluded).
- R11: If either write check byte differs from the computed CRC, `crc_error_o` goes high and stays high until reset. The 0x05 response is still sent.
- R12: Once initialized, any command other than 17 and 24 gets the single reply 0x00.
- R13: Sector reads return correct data when the host presents a byte on every clock cycle, despite the one-cycle memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_low_i | input | 1 | Select strobe (chip select driven low) |
| cs_high_i | input | 1 | Deselect strobe (chip select driven high) |
| wr_valid_i | input | 1 | Host presents one byte this cycle |
| wr_data_i | input | 8 | Byte sent by the host |
| rd_data_o | output | 8 | Byte the host reads back |
| crc_error_o | output | 1 | Sticky write CRC mismatch flag |
| mem_addr_o | output | 25 | Sector memory byte address |
| mem_wdata_o | output | 8 | Sector memory write data |
| mem_we_o | output | 1 | Sector memory write enable |
| mem_rdata_i | input | 8 | Sector memory read data, one cycle after the address |

## Verification
The hardest cases to reach are those behind the full handshake and a sector transfer. These are a write cancelled by a stray byte while the token is awaited, and a read driven at one byte per clock, where the early address is the only reason each byte is correct. The stimulus first drives the handshake through its failure paths: a frame inside the wake-up clocks, a wrong-argument command 8, and a command 55 sent too early. It then completes the handshake and reaches the data phases. Reads are run both with spaced bytes and as an unbroken burst. A write with corrupted check bytes is followed by a clean write to show that the error flag holds.

// File: rtl/sd_resp_pkg.sv
package sd_resp_pkg;
  localparam int QUEUE_SLOTS = 5;
  localparam int QUEUE_PW    = $clog2(QUEUE_SLOTS);

  localparam logic [7:0] BYTE_IDLE  = 8'hFF;
  localparam logic [7:0] BYTE_TOKEN = 8'hFE;
  localparam logic [7:0] BYTE_DACK  = 8'h05;
  localparam logic [7:0] BYTE_BUSY  = 8'h01;
  localparam logic [7:0] BYTE_OK    = 8'h00;

  typedef logic [QUEUE_SLOTS-1:0][7:0] resp_slots_t;

  typedef enum logic [1:0] {DM_IDLE, DM_READ, DM_WTOK, DM_WDATA} data_mode_e;
  typedef enum logic [2:0] {IS_WAKE, IS_CMD0, IS_CMD8, IS_CMD55, IS_CMD41, IS_READY} init_stage_e;

  function automatic logic [15:0] crc16_step(input logic [15:0] crc, input logic [7:0] d);
    logic [15:0] c;
    logic        fb;
    c = crc;
    for (int k = 7; k >= 0; k--) begin
      fb = c[15] ^ d[k];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction
endpackage

// File: rtl/sd_cmd_collector.sv
module sd_cmd_collector #(
  parameter int FRAME_BYTES = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_en_i,
  input  logic [7:0]  byte_i,
  output logic        frame_done_o,
  output logic [5:0]  cmd_o,
  output logic [31:0] arg_o
);
  localparam int IDX_W    = $clog2(FRAME_BYTES);
  localparam int ARG_BYTES = 4;

  logic [IDX_W-1:0] idx_q, idx_n;
  logic [5:0]       cmd_q;
  logic [7:0]       arg_q [ARG_BYTES];
  logic             take;

  always_comb begin
    take         = byte_en_i && ((idx_q != '0) || (byte_i[7:6] == 2'b01));
    frame_done_o = take && (idx_q == IDX_W'(FRAME_BYTES-1));
    idx_n        = idx_q;
    if (take) idx_n = frame_done_o ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cmd_q <= '0;
    end else begin
      idx_q <= idx_n;
      if (take && idx_q == '0) cmd_q <= byte_i[5:0];
    end
  end

  for (genvar g = 0; g < ARG_BYTES; g++) begin : g_arg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arg_q[g] <= '0;
      else if (take && idx_q == IDX_W'(g+1)) arg_q[g] <= byte_i;
    end
  end

  assign cmd_o = cmd_q;
  assign arg_o = {arg_q[0], arg_q[1], arg_q[2], arg_q[3]};
endmodule

// File: rtl/sd_resp_queue.sv
module sd_resp_queue
  import sd_resp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [QUEUE_PW-1:0] load_start_i,
  input  resp_slots_t         load_data_i,
  input  logic                pop_i,
  output logic                active_o,
  output logic [7:0]          head_o
);
  resp_slots_t         slot_q;
  logic [QUEUE_PW-1:0] ptr_q, ptr_n;
  logic                act_q, act_n;

  always_comb begin
    ptr_n = ptr_q;
    act_n = act_q;
    if (load_i) begin
      ptr_n = load_start_i;
      act_n = 1'b1;
    end else if (pop_i && act_q) begin
      ptr_n = ptr_q + 1'b1;
      if (ptr_q == QUEUE_PW'(QUEUE_SLOTS-1)) act_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      act_q <= 1'b0;
    end else begin
      ptr_q <= ptr_n;
      act_q <= act_n;
    end
  end

  for (genvar g = 0; g < QUEUE_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= BYTE_IDLE;
      else if (load_i) slot_q[g] <= load_data_i[g];
    end
  end

  assign active_o = act_q;
  assign head_o   = slot_q[ptr_q];
endmodule

// File: rtl/sd_spi_responder.sv
module sd_spi_responder
  import sd_resp_pkg::*;
#(
  parameter int SECTOR_BYTES  = 512,
  parameter int ARG_ADDR_BITS = 16,
  parameter int WAKE_CLOCKS   = 8
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          cs_low_i,
  input  logic                                          cs_high_i,
  input  logic                                          wr_valid_i,
  input  logic [7:0]                                    wr_data_i,
  output logic [7:0]                                    rd_data_o,
  output logic                                          crc_error_o,
  output logic [ARG_ADDR_BITS+$clog2(SECTOR_BYTES)-1:0] mem_addr_o,
  output logic [7:0]                                    mem_wdata_o,
  output logic                                          mem_we_o,
  input  logic [7:0]                                    mem_rdata_i
);
  localparam int SECT_W = $clog2(SECTOR_BYTES);
  localparam int CNT_W  = SECT_W + 1;
  localparam int WAKE_W = $clog2(WAKE_CLOCKS + 1);

  logic                     sel_q, sel_n;
  init_stage_e              stage_q, stage_n;
  logic [WAKE_W-1:0]        wake_q, wake_n;
  logic [7:0]               resp_q, resp_n;
  data_mode_e               mode_q, mode_n;
  logic [CNT_W-1:0]         cnt_q, cnt_n;
  logic [ARG_ADDR_BITS-1:0] base_q, base_n;
  logic [15:0]              crc_q, crc_n;
  logic                     err_q, err_n;

  logic                acc;
  logic                q_active, q_pop, q_load;
  logic [7:0]          q_head;
  logic [QUEUE_PW-1:0] q_start;
  resp_slots_t         q_data;
  logic                col_en, frame_done;
  logic [5:0]          f_cmd;
  logic [31:0]         f_arg;
  logic                we;
  logic [SECT_W-1:0]   cnt_sel;

  sd_cmd_collector #(.FRAME_BYTES(6)) u_collector (
    .clk(clk), .rst_n(rst_n), .byte_en_i(col_en), .byte_i(wr_data_i),
    .frame_done_o(frame_done), .cmd_o(f_cmd), .arg_o(f_arg)
  );

  sd_resp_queue u_queue (
    .clk(clk), .rst_n(rst_n), .load_i(q_load), .load_start_i(q_start),
    .load_data_i(q_data), .pop_i(q_pop), .active_o(q_active), .head_o(q_head)
  );

  always_comb begin
    acc     = sel_q && wr_valid_i;
    sel_n   = cs_high_i ? 1'b0 : (cs_low_i ? 1'b1 : sel_q);
    stage_n = stage_q;
    wake_n  = wake_q;
    resp_n  = resp_q;
    mode_n  = mode_q;
    cnt_n   = cnt_q;
    base_n  = base_q;
    crc_n   = crc_q;
    err_n   = err_q;
    q_pop   = 1'b0;
    q_load  = 1'b0;
    q_start = QUEUE_PW'(QUEUE_SLOTS-1);
    q_data  = {QUEUE_SLOTS{BYTE_IDLE}};
    col_en  = 1'b0;
    we      = 1'b0;
    if (acc) begin
      resp_n = BYTE_IDLE;
      if (stage_q == IS_WAKE) begin
        wake_n = wake_q + 1'b1;
        if (wake_q == WAKE_W'(WAKE_CLOCKS-1)) stage_n = IS_CMD0;
      end else if (q_active) begin
        q_pop  = 1'b1;
        resp_n = q_head;
      end else begin
        unique case (mode_q)
          DM_READ: begin
            resp_n = mem_rdata_i;
            crc_n  = crc16_step(crc_q, mem_rdata_i);
            cnt_n  = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(SECTOR_BYTES-1)) begin
              q_load     = 1'b1;
              q_start    = QUEUE_PW'(QUEUE_SLOTS-2);
              q_data[QUEUE_SLOTS-2] = crc_n[15:8];
              q_data[QUEUE_SLOTS-1] = crc_n[7:0];
              mode_n     = DM_IDLE;
            end
          end
          DM_WTOK: begin
            if (wr_data_i == BYTE_TOKEN) begin
              mode_n = DM_WDATA;
              cnt_n  = '0;
            end else if (wr_data_i != BYTE_IDLE) begin
              mode_n = DM_IDLE;
            end
          end
          DM_WDATA: begin
            cnt_n = cnt_q + 1'b1;
            if (cnt_q < CNT_W'(SECTOR_BYTES)) begin
              we    = 1'b1;
              crc_n = crc16_step(crc_q, wr_data_i);
            end else if (cnt_q == CNT_W'(SECTOR_BYTES)) begin
              if (wr_data_i != crc_q[15:8]) err_n = 1'b1;
            end else begin
              if (wr_data_i != crc_q[7:0]) err_n = 1'b1;
              q_load = 1'b1;
              q_data[QUEUE_SLOTS-1] = BYTE_DACK;
              mode_n = DM_IDLE;
            end
          end
          default: begin
            col_en = 1'b1;
            if (frame_done) begin
              unique case (stage_q)
                IS_CMD0: begin
                  if (f_cmd == 6'd0) begin
                    stage_n = IS_CMD8;
                    q_load  = 1'b1;
                    q_data[QUEUE_SLOTS-1] = BYTE_BUSY;
                  end
                end
                IS_CMD8: begin
                  if (f_cmd == 6'd8 && f_arg[15:0] == 16'h01AA) begin
                    stage_n = IS_CMD55;
                    q_load  = 1'b1;
                    q_start = '0;
                    q_data  = {8'hAA, 8'h01, 8'h00, 8'h00, BYTE_BUSY};
                  end else begin
                    stage_n = IS_CMD0;
                  end
                end
                IS_CMD55: begin
                  if (f_cmd == 6'd55) begin
                    stage_n = IS_CMD41;
                    q_load  = 1'b1;
                    q_data[QUEUE_SLOTS-1] = BYTE_BUSY;
                  end else begin
                    stage_n = IS_CMD0;
                  end
                end
                IS_CMD41: begin
                  if (f_cmd == 6'd41 && f_arg[31:16] == 16'h4000) begin
                    stage_n = IS_READY;
                    q_load  = 1'b1;
                    q_data[QUEUE_SLOTS-1] = BYTE_OK;
                  end else begin
                    stage_n = IS_CMD0;
                  end
                end
                default: begin
                  q_load = 1'b1;
                  q_data[QUEUE_SLOTS-1] = BYTE_OK;
                  if (f_cmd == 6'd17) begin
                    q_start = QUEUE_PW'(QUEUE_SLOTS-2);
                    q_data[QUEUE_SLOTS-2] = BYTE_OK;
                    q_data[QUEUE_SLOTS-1] = BYTE_TOKEN;
                    mode_n  = DM_READ;
                    cnt_n   = '0;
                    crc_n   = '0;
                    base_n  = f_arg[ARG_ADDR_BITS-1:0];
                  end else if (f_cmd == 6'd24) begin
                    mode_n  = DM_WTOK;
                    cnt_n   = '0;
                    crc_n   = '0;
                    base_n  = f_arg[ARG_ADDR_BITS-1:0];
                  end
                end
              endcase
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      stage_q <= IS_WAKE;
      wake_q  <= '0;
      resp_q  <= BYTE_IDLE;
      mode_q  <= DM_IDLE;
      cnt_q   <= '0;
      base_q  <= '0;
      crc_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      sel_q   <= sel_n;
      stage_q <= stage_n;
      wake_q  <= wake_n;
      resp_q  <= resp_n;
      mode_q  <= mode_n;
      cnt_q   <= cnt_n;
      base_q  <= base_n;
      crc_q   <= crc_n;
      err_q   <= err_n;
    end
  end

  // Early address: while a read byte is consumed, fetch the one after it.
  always_comb begin
    cnt_sel = cnt_q[SECT_W-1:0];
    if (acc && !q_active && mode_q == DM_READ) cnt_sel = cnt_q[SECT_W-1:0] + 1'b1;
  end

  assign mem_addr_o  = {base_q, cnt_sel};
  assign mem_wdata_o = wr_data_i;
  assign mem_we_o    = we;
  assign rd_data_o   = sel_q ? resp_q : BYTE_IDLE;
  assign crc_error_o = err_q;
endmodule

// File: rtl/sd_spi_responder_checker.sv
module sd_spi_responder_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_low_i,
  input logic       cs_high_i,
  input logic       wr_valid_i,
  input logic [7:0] rd_data_o,
  input logic       crc_error_o,
  input logic       mem_we_o
);
  assert_deselect_ff_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high_i |=> rd_data_o == 8'hFF);

  assert_resp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid_i && !cs_low_i && !cs_high_i) |=> $stable(rd_data_o));

  assert_write_needs_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> wr_valid_i);

  assert_crc_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    crc_error_o |=> crc_error_o);
endmodule

bind sd_spi_responder sd_spi_responder_checker u_checker (
  .clk(clk), .rst_n(rst_n), .cs_low_i(cs_low_i), .cs_high_i(cs_high_i),
  .wr_valid_i(wr_valid_i), .rd_data_o(rd_data_o), .crc_error_o(crc_error_o),
  .mem_we_o(mem_we_o)
);

// File: tb/sd_spi_responder_bench.sv
module sd_spi_responder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SB = 512;
  localparam int MEM_BYTES = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_low = 1'b0, cs_high = 1'b0, wr_valid = 1'b0;
  logic [7:0]  wr_data = 8'hFF;
  logic [7:0]  rd_data;
  logic        crc_err;
  logic [24:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we;

  logic [7:0] mem [MEM_BYTES];
  logic [7:0] rbuf [SB+4];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_spi_responder u_sd_spi_responder (
    .clk(clk), .rst_n(rst_n), .cs_low_i(cs_low), .cs_high_i(cs_high),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .crc_error_o(crc_err), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] init_pat(int i);
    return 8'((i * 37 + 11) ^ (i >> 7));
  endfunction

  function automatic logic [7:0] wr_pat(int i, int s);
    return 8'(i ^ 8'h5A ^ (i >> 3) ^ (s * 17));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= init_pat(i);
    end else begin
      mem_rdata <= mem[mem_addr[10:0]];
      if (mem_we) mem[mem_addr[10:0]] <= mem_wdata;
    end
  end

  function automatic logic [15:0] bcrc(logic [15:0] c, logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    wr_valid = 1'b0;
    wr_data  = 8'hFF;
    r = rd_data;
  endtask

  task automatic expect_resp(input logic [7:0] exp, input string tag);
    logic [7:0] r;
    xfer(8'hFF, r);
    check(r == exp, tag, r, exp);
  endtask

  task automatic send_cmd(input int c, input logic [31:0] a, output logic [7:0] last);
    logic [7:0] r;
    xfer(8'h40 | 8'(c), r);
    xfer(a[31:24], r);
    xfer(a[23:16], r);
    xfer(a[15:8], r);
    xfer(a[7:0], r);
    xfer(8'h95, last);
  endtask

  task automatic strobe(input bit lo);
    @(negedge clk);
    if (lo) cs_low = 1'b1; else cs_high = 1'b1;
    @(negedge clk);
    cs_low = 1'b0;
    cs_high = 1'b0;
  endtask

  task automatic burst(input int n);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = 8'hFF;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rbuf[i] = rd_data;
    end
    wr_valid = 1'b0;
  endtask

  task automatic read_sector(input int s, input logic [31:0] arg, input bit fast, input string tag);
    logic [7:0] r;
    logic [15:0] c;
    int mism;
    send_cmd(17, arg, r);
    check(r == 8'hFF, "R2 response trails frame", r, 8'hFF);
    if (fast) burst(SB + 4);
    else for (int i = 0; i < SB + 4; i++) xfer(8'hFF, rbuf[i]);
    check(rbuf[0] == 8'h00, {tag, " R7 read reply"}, rbuf[0], 8'h00);
    check(rbuf[1] == 8'hFE, {tag, " R7 read token"}, rbuf[1], 8'hFE);
    c = 16'h0;
    mism = 0;
    for (int i = 0; i < SB; i++) begin
      if (rbuf[i+2] != mem[s*SB + i]) mism++;
      c = bcrc(c, mem[s*SB + i]);
    end
    check(mism == 0, {tag, " R7 sector data mismatches"}, mism, 0);
    check(rbuf[SB+2] == c[15:8], {tag, " R10 crc high"}, rbuf[SB+2], c[15:8]);
    check(rbuf[SB+3] == c[7:0], {tag, " R10 crc low"}, rbuf[SB+3], c[7:0]);
  endtask

  task automatic write_sector(input int s, input bit good);
    logic [7:0] r;
    logic [15:0] c;
    int mism;
    send_cmd(24, s, r);
    expect_resp(8'h00, "R8 write reply");
    for (int i = 0; i < 3; i++) expect_resp(8'hFF, "R8 idle skipped");
    xfer(8'hFE, r);
    c = 16'h0;
    for (int i = 0; i < SB; i++) begin
      xfer(wr_pat(i, s), r);
      c = bcrc(c, wr_pat(i, s));
    end
    if (!good) c = ~c;
    xfer(c[15:8], r);
    xfer(c[7:0], r);
    expect_resp(8'h05, "R8 R11 data response");
    mism = 0;
    for (int i = 0; i < SB; i++) if (mem[s*SB + i] != wr_pat(i, s)) mism++;
    check(mism == 0, "R8 memory written", mism, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int mism;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == 8'hFF, "R1 reset read", rd_data, 8'hFF);
    check(crc_err == 1'b0, "R11 reset flag", crc_err, 0);

    // R1: deselected bytes neither respond nor count as wake clocks
    for (int i = 0; i < 10; i++) xfer(8'h40, r);
    check(r == 8'hFF, "R1 deselected read", r, 8'hFF);

    strobe(1'b1);
    // R3: a command 0 frame inside the wake clocks is ignored
    mism = 0;
    send_cmd(0, 32'h0, r);
    if (r != 8'hFF) mism++;
    xfer(8'hFF, r); if (r != 8'hFF) mism++;
    xfer(8'hFF, r); if (r != 8'hFF) mism++;
    check(mism == 0, "R3 wake clocks ignored", mism, 0);
    expect_resp(8'hFF, "R3 no reply after wake frame");

    // R4 junk bytes dropped, R6 early command 55 ignored
    xfer(8'h12, r); xfer(8'h80, r); xfer(8'h3F, r);
    send_cmd(55, 32'h0, r);
    expect_resp(8'hFF, "R6 no reply before command 0");
    send_cmd(0, 32'h0, r);
    check(r == 8'hFF, "R2 reply not on sixth byte", r, 8'hFF);
    expect_resp(8'h01, "R5 command 0 reply");
    expect_resp(8'hFF, "R2 reply consumed");

    // R6: wrong argument sends handshake back to command 0
    send_cmd(8, 32'h000001AB, r);
    expect_resp(8'hFF, "R6 bad command 8");
    send_cmd(55, 32'h0, r);
    expect_resp(8'hFF, "R6 back at command 0 stage");
    send_cmd(0, 32'h0, r);
    expect_resp(8'h01, "R5 command 0 again");
    send_cmd(8, 32'h000001AA, r);
    expect_resp(8'h01, "R5 cmd8 byte0");
    expect_resp(8'h00, "R5 cmd8 byte1");
    expect_resp(8'h00, "R5 cmd8 byte2");
    expect_resp(8'h01, "R5 cmd8 byte3");
    expect_resp(8'hAA, "R5 cmd8 byte4");
    expect_resp(8'hFF, "R5 cmd8 queue empty");
    send_cmd(55, 32'h0, r);
    expect_resp(8'h01, "R5 command 55 reply");
    send_cmd(41, 32'h40000000, r);
    expect_resp(8'h00, "R5 command 41 reply");

    send_cmd(13, 32'h0, r);
    expect_resp(8'h00, "R12 unsupported command");
    expect_resp(8'hFF, "R12 single byte only");

    read_sector(1, 32'h00000001, 1'b0, "spaced");
    expect_resp(8'hFF, "R7 read finished");
    read_sector(2, 32'hABCD0002, 1'b1, "R4 R13 burst");
    expect_resp(8'hFF, "R13 burst finished");

    write_sector(3, 1'b1);
    check(crc_err == 1'b0, "R11 good crc no flag", crc_err, 0);
    read_sector(3, 32'h00000003, 1'b1, "readback");

    // R9: stray byte cancels a write
    send_cmd(24, 32'h0, r);
    expect_resp(8'h00, "R9 write reply");
    xfer(8'h33, r);
    xfer(8'hFE, r);
    for (int i = 0; i < 10; i++) xfer(8'h11, r);
    mism = 0;
    for (int i = 0; i < SB; i++) if (mem[i] != init_pat(i)) mism++;
    check(mism == 0, "R9 memory untouched", mism, 0);
    send_cmd(13, 32'h0, r);
    expect_resp(8'h00, "R9 parser live after abort");

    write_sector(0, 1'b0);
    check(crc_err == 1'b1, "R11 bad crc flag", crc_err, 1);
    write_sector(1, 1'b1);
    check(crc_err == 1'b1, "R11 flag sticky", crc_err, 1);

    // R1: deselect discards a frame
    strobe(1'b0);
    check(rd_data == 8'hFF, "R1 read while deselected", rd_data, 8'hFF);
    send_cmd(13, 32'h0, r);
    xfer(8'hFF, r);
    check(r == 8'hFF, "R1 deselected frame read", r, 8'hFF);
    strobe(1'b1);
    expect_resp(8'hFF, "R1 no reply to ignored frame");
    send_cmd(13, 32'h0, r);
    expect_resp(8'h00, "R1 reselected works");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule